// File: doc/BRIEF.md
# External Interrupt Detector

This block turns external pins into interrupt requests for a processor core. It has two independent channels. Each channel watches one input pin, chosen from eight by a select field, and brings that pin into the system clock domain. It then decides whether the pin is requesting service. The block never drives the pins, so several watchers and any other peripheral can share a pin freely.

A channel is set to one of four setups. Its polarity bit chooses an active-high or active-low input. Its mode bit chooses how the request is formed. In edge mode an active transition latches a pending flag. That flag clears when the core acknowledges the channel's vector, or when software writes it. In level mode the request simply follows the qualified input, so a source that keeps its input active is served again after each acknowledge. Software reaches the configuration and the pending flags through a small byte-wide register port.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, both configuration bytes read 0 (pin 0, active low, level mode). With all pins held high, both `irq` bits are 0 and the flag byte reads 0.
- R2: Configuration byte bits [2:0] select the watched pin. A change on any other pin has no effect on that channel's `irq`.
- R3: In level mode, `irq` equals the selected pin when polarity bit [3] is 1, and its inverse when bit [3] is 0. A pin change reaches `irq` after exactly two clock edges.
- R4: In level mode the request is not latched. It drops as soon as the synchronised input goes inactive. An acknowledge does not clear it while the input stays active.
- R5: In edge mode (bit [4] = 1), an active transition sets the pending flag: low to high when the polarity is high, high to low when it is low. `irq` rises on the third clock edge after the pin changes. The flag stays set after the input returns, and an inactive transition does not set it.
- R6: In edge mode, a one-cycle pulse on a channel's `vec_ack` bit clears its pending flag at the next edge.
- R7: Writing the flag register (address 2) in edge mode loads each channel's flag from bit n of the data: 0 clears and 1 sets. In level mode such a write has no effect.
- R8: When an active edge is detected in the same cycle as a software clear or an acknowledge, the flag ends set.
- R9: Changing polarity, pin select or mode through a configuration write never creates a pending flag by itself.
- R10: The two channels are independent. They may watch the same pin, and acknowledging one leaves the other's flag unchanged.
- R11: Address n (0 or 1) reads and writes channel n's configuration byte, with bits [7:5] reading 0. Address 2 reads the two `irq` bits in bits [1:0]. Address 3 reads 0.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 8 | Asynchronous external pins that may be watched |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| vec_ack | input | 2 | Per-channel vector acknowledge pulse from the core |
| irq | output | 2 | Per-channel interrupt request (pending flag or qualified level) |

## Verification
The hardest case to reach from the ports is an active edge in the same cycle as a software clear or an acknowledge. The edge exists only inside the block, two edges after the pin moves. The stimulus changes the pin at a falling clock edge and waits two rising edges. It then raises the write strobe or the acknowledge, so that it is sampled exactly at the detection edge. False edges from reconfiguration are provoked in a similar way. The stimulus first parks a different level on the newly selected pin, or holds the input active, and only then rewrites select, polarity or mode.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   typedef enum logic {
      DET_LEVEL = 1'b0,
      DET_EDGE  = 1'b1
   } det_mode_e;

   // Map a raw synchronised sample to "request active" under a polarity.
   function automatic logic qualify(input logic raw, input logic act_high);
      return act_high ? raw : ~raw;
   endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int   WIDTH     = 8,
   parameter int   STAGES    = 2,
   parameter logic RESET_BIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ext_irq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ext_irq_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= {WIDTH{RESET_BIT}};
            else        chain[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= {WIDTH{RESET_BIT}};
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs #(
   parameter int NUM_CH = 2,
   parameter int SEL_W  = 3,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_wr,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [DATA_W-1:0]            reg_wdata,
   output logic [DATA_W-1:0]            reg_rdata,
   input  logic [NUM_CH-1:0]            irq,
   output logic [NUM_CH-1:0][SEL_W-1:0] cfg_sel,
   output logic [NUM_CH-1:0]            cfg_act_high,
   output logic [NUM_CH-1:0]            cfg_edge,
   output logic [NUM_CH-1:0]            cfg_load,
   output logic [SEL_W-1:0]             load_sel,
   output logic                         flag_we,
   output logic [NUM_CH-1:0]            flag_wdata
);

   localparam int POL_BIT  = SEL_W;
   localparam int MODE_BIT = SEL_W + 1;
   localparam int CFG_W    = SEL_W + 2;
   localparam int USED_W   = (CFG_W > NUM_CH) ? CFG_W : NUM_CH;
   localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_CH);

   if (CFG_W > DATA_W) begin : g_bad_cfg
      $error("ext_irq_regs: configuration byte wider than DATA_W");
   end
   if (NUM_CH > DATA_W) begin : g_bad_flags
      $error("ext_irq_regs: flag register wider than DATA_W");
   end
   if ((1 << ADDR_W) < NUM_CH + 1) begin : g_bad_addr
      $error("ext_irq_regs: ADDR_W too small for register map");
   end

   if (DATA_W > USED_W) begin : g_spare
      logic spare_unused;
      assign spare_unused = ^reg_wdata[DATA_W-1:USED_W];
   end

   assign load_sel   = reg_wdata[SEL_W-1:0];
   assign flag_we    = reg_wr && (reg_addr == FLAG_ADDR);
   assign flag_wdata = reg_wdata[NUM_CH-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(c);

      assign cfg_load[c] = reg_wr && (reg_addr == MY_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_sel[c]      <= '0;
            cfg_act_high[c] <= 1'b0;
            cfg_edge[c]     <= 1'b0;
         end else if (cfg_load[c]) begin
            cfg_sel[c]      <= reg_wdata[SEL_W-1:0];
            cfg_act_high[c] <= reg_wdata[POL_BIT];
            cfg_edge[c]     <= reg_wdata[MODE_BIT];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (reg_addr == ADDR_W'(c)) begin
            reg_rdata[SEL_W-1:0] = cfg_sel[c];
            reg_rdata[POL_BIT]   = cfg_act_high[c];
            reg_rdata[MODE_BIT]  = cfg_edge[c];
         end
      end
      if (reg_addr == FLAG_ADDR) reg_rdata[NUM_CH-1:0] = irq;
   end

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
   import ext_irq_pkg::*;
#(
   parameter int   NUM_PINS   = 8,
   parameter int   SEL_W      = 3,
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] sync_pins,
   input  logic [SEL_W-1:0]    sel,
   input  logic                act_high,
   input  logic                edge_mode,
   input  logic                cfg_load,
   input  logic [SEL_W-1:0]    load_sel,
   input  logic                ack,
   input  logic                flag_we,
   input  logic                flag_wbit,
   output logic                irq,
   output logic                edge_hit
);

   det_mode_e mode;
   logic      raw_now;
   logic      prev_raw;
   logic      qual_now;
   logic      qual_prev;
   logic      pend;

   assign mode    = edge_mode ? DET_EDGE : DET_LEVEL;
   assign raw_now = sync_pins[sel];

   // Previous sample kept raw: a polarity change qualifies both samples
   // alike, and a select change reloads it from the new pin.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_raw <= IDLE_LEVEL;
      else if (cfg_load) prev_raw <= sync_pins[load_sel];
      else               prev_raw <= raw_now;
   end

   assign qual_now  = qualify(raw_now, act_high);
   assign qual_prev = qualify(prev_raw, act_high);
   assign edge_hit  = qual_now & ~qual_prev;

   // Priority: detected edge, then acknowledge, then software write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pend <= 1'b0;
      else if (mode == DET_LEVEL) pend <= 1'b0;
      else if (edge_hit)          pend <= 1'b1;
      else if (ack)               pend <= 1'b0;
      else if (flag_we)           pend <= flag_wbit;
   end

   assign irq = (mode == DET_EDGE) ? pend : qual_now;

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
   parameter int   NUM_CH      = 2,
   parameter int   NUM_PINS    = 8,
   parameter int   SYNC_STAGES = 2,
   parameter int   DATA_W      = 8,
   parameter logic IDLE_LEVEL  = 1'b1,
   localparam int  SEL_W       = $clog2(NUM_PINS),
   localparam int  ADDR_W      = $clog2(NUM_CH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_CH-1:0]   vec_ack,
   output logic [NUM_CH-1:0]   irq
);

   if (NUM_PINS < 2 || (1 << SEL_W) != NUM_PINS) begin : g_bad_pins
      $error("ext_irq_detect: NUM_PINS must be a power of two, at least 2");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("ext_irq_detect: NUM_CH must be positive");
   end

   logic [NUM_PINS-1:0]            sync_pins;
   logic [NUM_CH-1:0][SEL_W-1:0]   cfg_sel;
   logic [NUM_CH-1:0]              cfg_act_high;
   logic [NUM_CH-1:0]              cfg_edge;
   logic [NUM_CH-1:0]              cfg_load;
   logic [SEL_W-1:0]               load_sel;
   logic                           flag_we;
   logic [NUM_CH-1:0]              flag_wdata;
   logic [NUM_CH-1:0]              edge_hit;

   // One shared synchroniser bank: select changes never see stale stages.
   ext_irq_sync #(
      .WIDTH     (NUM_PINS),
      .STAGES    (SYNC_STAGES),
      .RESET_BIT (IDLE_LEVEL)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pins),
      .dout (sync_pins)
   );

   ext_irq_regs #(
      .NUM_CH(NUM_CH),
      .SEL_W (SEL_W),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq         (irq),
      .cfg_sel     (cfg_sel),
      .cfg_act_high(cfg_act_high),
      .cfg_edge    (cfg_edge),
      .cfg_load    (cfg_load),
      .load_sel    (load_sel),
      .flag_we     (flag_we),
      .flag_wdata  (flag_wdata)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ext_irq_chan #(
         .NUM_PINS  (NUM_PINS),
         .SEL_W     (SEL_W),
         .IDLE_LEVEL(IDLE_LEVEL)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .sync_pins(sync_pins),
         .sel      (cfg_sel[c]),
         .act_high (cfg_act_high[c]),
         .edge_mode(cfg_edge[c]),
         .cfg_load (cfg_load[c]),
         .load_sel (load_sel),
         .ack      (vec_ack[c]),
         .flag_we  (flag_we),
         .flag_wbit(flag_wdata[c]),
         .irq      (irq[c]),
         .edge_hit (edge_hit[c])
      );
   end

endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
   parameter int   NUM_CH      = 2,
   parameter int   NUM_PINS    = 8,
   parameter int   SYNC_STAGES = 2,
   parameter int   SEL_W       = 3,
   parameter int   ADDR_W      = 2,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_PINS-1:0]          pins,
   input logic                         reg_wr,
   input logic [ADDR_W-1:0]            reg_addr,
   input logic [NUM_CH-1:0]            vec_ack,
   input logic [NUM_CH-1:0]            irq,
   input logic [NUM_CH-1:0][SEL_W-1:0] cfg_sel,
   input logic [NUM_CH-1:0]            cfg_act_high,
   input logic [NUM_CH-1:0]            cfg_edge,
   input logic [NUM_CH-1:0]            edge_hit
);

   logic [SYNC_STAGES-1:0][NUM_PINS-1:0] pin_hist;
   logic                                 flag_wr;

   assign flag_wr = reg_wr && (reg_addr == ADDR_W'(NUM_CH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_hist <= {(SYNC_STAGES*NUM_PINS){IDLE_LEVEL}};
      end else begin
         pin_hist[0] <= pins;
         for (int s = 1; s < SYNC_STAGES; s++) pin_hist[s] <= pin_hist[s-1];
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      logic old_pin;
      assign old_pin = pin_hist[SYNC_STAGES-1][cfg_sel[c]];

      // R3 / R4: level mode follows the pin as it was SYNC_STAGES edges ago
      a_r3_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_edge[c] |-> (irq[c] == (cfg_act_high[c] ? old_pin : ~old_pin)));

      // R5 and R8: a detected edge always leaves the flag set
      a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_edge[c] && edge_hit[c]) |=> (irq[c] || !cfg_edge[c]));

      a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_edge[c] && vec_ack[c] && !edge_hit[c]) |=> (!irq[c] || !cfg_edge[c]));

      // R9: without edge, acknowledge or flag write the edge flag holds
      a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_edge[c] && !edge_hit[c] && !vec_ack[c] && !flag_wr)
            |=> ($stable(irq[c]) || !cfg_edge[c]));
   end

endmodule

bind ext_irq_detect ext_irq_detect_chk #(
   .NUM_CH     (NUM_CH),
   .NUM_PINS   (NUM_PINS),
   .SYNC_STAGES(SYNC_STAGES),
   .SEL_W      (SEL_W),
   .ADDR_W     (ADDR_W),
   .IDLE_LEVEL (IDLE_LEVEL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pins        (pins),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .vec_ack     (vec_ack),
   .irq         (irq),
   .cfg_sel     (cfg_sel),
   .cfg_act_high(cfg_act_high),
   .cfg_edge    (cfg_edge),
   .edge_hit    (edge_hit)
);

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] pins;
   logic       reg_wr;
   logic [1:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic [1:0] vec_ack;
   logic [1:0] irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_irq_detect uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins     (pins),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .vec_ack  (vec_ack),
      .irq      (irq)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic ack(input logic [1:0] m);
      vec_ack = m;
      @(negedge clk);
      vec_ack = 2'b00;
   endtask

   task automatic t_reset;
      chk("R1 irq after reset", {6'b0, irq}, 8'h00);
      rd_chk("R1 cfg0 reset", 2'd0, 8'h00);
      rd_chk("R1 cfg1 reset", 2'd1, 8'h00);
      rd_chk("R1 flags reset", 2'd2, 8'h00);
   endtask

   task automatic t_level;
      pins = 8'hF7;
      tick(3);
      wr(2'd0, 8'h0B);                       // pin3, active high, level
      chk("R3 pin3 low inactive", {7'b0, irq[0]}, 8'h00);
      pins[3] = 1'b1;
      tick(1);
      chk("R3 one edge not yet", {7'b0, irq[0]}, 8'h00);
      tick(1);
      chk("R3 two edges active", {7'b0, irq[0]}, 8'h01);
      pins[2] = 1'b0; pins[4] = 1'b0;
      tick(3);
      chk("R2 other pins ignored", {7'b0, irq[0]}, 8'h01);
      pins[2] = 1'b1; pins[4] = 1'b1;
      pins[3] = 1'b0;
      tick(2);
      chk("R4 level drops", {7'b0, irq[0]}, 8'h00);
      pins[3] = 1'b1;
      tick(2);
      ack(2'b01);
      chk("R4 ack ignored in level", {7'b0, irq[0]}, 8'h01);
      rd_chk("R11 flag read", 2'd2, 8'h01);
      wr(2'd2, 8'h00);
      chk("R7 write ignored in level", {7'b0, irq[0]}, 8'h01);
      wr(2'd0, 8'h03);                       // active low, pin3 high
      chk("R3 active low inactive", {7'b0, irq[0]}, 8'h00);
      pins[3] = 1'b0;
      tick(2);
      chk("R3 active low active", {7'b0, irq[0]}, 8'h01);
      pins[3] = 1'b1;
      tick(2);
      chk("R3 active low released", {7'b0, irq[0]}, 8'h00);
   endtask

   task automatic t_edge;
      wr(2'd0, 8'h1D);                       // pin5, active high, edge
      chk("R9 level to edge no flag", {7'b0, irq[0]}, 8'h00);
      pins[5] = 1'b0;
      tick(3);
      chk("R5 falling ignored", {7'b0, irq[0]}, 8'h00);
      pins[5] = 1'b1;
      tick(2);
      chk("R5 not before third edge", {7'b0, irq[0]}, 8'h00);
      tick(1);
      chk("R5 rising sets", {7'b0, irq[0]}, 8'h01);
      pins[5] = 1'b0;
      tick(3);
      chk("R5 latched", {7'b0, irq[0]}, 8'h01);
      rd_chk("R11 edge flag read", 2'd2, 8'h01);
      ack(2'b01);
      chk("R6 ack clears", {7'b0, irq[0]}, 8'h00);
      wr(2'd0, 8'h15);                       // active low, pin5 low now
      tick(3);
      chk("R9 polarity change no flag", {7'b0, irq[0]}, 8'h00);
      pins[5] = 1'b1;
      tick(3);
      chk("R5 rising ignored active low", {7'b0, irq[0]}, 8'h00);
      pins[5] = 1'b0;
      tick(3);
      chk("R5 falling sets active low", {7'b0, irq[0]}, 8'h01);
      ack(2'b01);
      chk("R6 ack clears active low", {7'b0, irq[0]}, 8'h00);
      pins[5] = 1'b1;
      tick(3);
   endtask

   task automatic t_sw;
      wr(2'd2, 8'h01);
      chk("R7 write 1 sets", {7'b0, irq[0]}, 8'h01);
      wr(2'd2, 8'h00);
      chk("R7 write 0 clears", {7'b0, irq[0]}, 8'h00);
      wr(2'd2, 8'h02);
      chk("R7 level channel write ignored", {6'b0, irq}, 8'h00);
   endtask

   task automatic t_race;
      wr(2'd0, 8'h1D);                       // pin5 high, active high, edge
      pins[5] = 1'b0;
      tick(3);
      pins[5] = 1'b1;
      tick(2);                               // edge detected at next rising edge
      wr(2'd2, 8'h00);
      chk("R8 edge beats sw clear", {7'b0, irq[0]}, 8'h01);
      ack(2'b01);
      chk("R6 ack clears after race", {7'b0, irq[0]}, 8'h00);
      pins[5] = 1'b0;
      tick(3);
      pins[5] = 1'b1;
      tick(2);
      ack(2'b01);
      chk("R8 edge beats ack", {7'b0, irq[0]}, 8'h01);
      ack(2'b01);
      chk("R6 ack clears again", {7'b0, irq[0]}, 8'h00);
   endtask

   task automatic t_cfg;
      wr(2'd0, 8'h15);                       // active low, pin5 high
      tick(3);
      chk("R9 polarity flip no flag", {7'b0, irq[0]}, 8'h00);
      pins[1] = 1'b0;
      tick(3);
      wr(2'd0, 8'h11);                       // select pin1 (low, active)
      tick(3);
      chk("R9 select change no flag", {7'b0, irq[0]}, 8'h00);
      wr(2'd0, 8'h01);
      chk("R9 level mode active now", {7'b0, irq[0]}, 8'h01);
      wr(2'd0, 8'h11);
      tick(3);
      chk("R9 mode change no flag", {7'b0, irq[0]}, 8'h00);
      pins[1] = 1'b1;
      tick(3);
   endtask

   task automatic t_indep;
      wr(2'd0, 8'h1E);
      wr(2'd1, 8'h1E);
      tick(3);
      chk("R10 both idle", {6'b0, irq}, 8'h00);
      pins[6] = 1'b0;
      tick(3);
      pins[6] = 1'b1;
      tick(3);
      chk("R10 shared pin both set", {6'b0, irq}, 8'h03);
      ack(2'b10);
      chk("R10 ack one channel", {6'b0, irq}, 8'h01);
      rd_chk("R11 cfg1 readback", 2'd1, 8'h1E);
      rd_chk("R11 cfg0 readback", 2'd0, 8'h1E);
      rd_chk("R11 flag byte", 2'd2, 8'h01);
      rd_chk("R11 unused address", 2'd3, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      pins      = 8'hFF;
      reg_wr    = 1'b0;
      reg_addr  = 2'd0;
      reg_wdata = 8'h00;
      vec_ack   = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick(1);
      t_reset;
      t_level;
      t_edge;
      t_sw;
      t_race;
      t_cfg;
      t_indep;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule